// File: doc/BRIEF.md
# Receive Completion Status Ring Writer

This block sits at the end of a receive datapath. It turns the per-buffer results of frame reception into 128-bit completion entries and writes them into a circular status ring in memory that software drains. Each accepted request describes one filled receive buffer. The request carries several groups of fields: the link-layer status code and the network- and transport-layer checksum results; the flow identifier, the MAC identifier and its valid flag; six packet-type flags; three header lengths, the MCS, the bonding mode and the data-offset code; and the buffer identifier, the valid byte count and a timestamp.

The writer derives a summary error bit from the three status fields. It flags the entry that closes an MSDU, and it stamps every entry with a ready phase bit. That bit is 1 on the first pass through the ring and flips on every wrap, so software can tell fresh entries from stale ones without clearing the ring. The write appears on a simple memory write port one cycle after the handshake, and the hardware head pointer moves with it. A one-cycle interrupt pulse follows each committed entry that closes an MSDU. The software tail is an input, and the writer holds off its request handshake while the ring is full.

Top module: `rxs_ring_writer`

## Requirements
- R1: Entry bits 2:0 carry the link-layer status code (0 success, 1 MIC, 2 key, 3 replay, 4 A-MSDU, 7 FCS). Bits 4:3 carry the network-layer result and bits 6:5 the transport-layer result, where bit 0 of each means "identified, checksum computed" and bit 1 means "checksum error". Bit 7 is zero.
- R2: Entry bit 29 is 1 exactly when the link-layer code is nonzero, or the network-layer result is 3, or the transport-layer result is 3.
- R3: Entry bit 30 is 1 only when the request is marked as the last buffer of its MSDU.
- R4: Entry bit 31 is 1 for every entry written during the first pass through the ring after reset. It inverts each time the write address wraps from the last slot to slot 0.
- R5: Entry bits 19:8 hold the flow id and bits 21:20 the MAC id. Bit 22 holds the MAC id valid flag, and bits 21:20 are zero when that flag is low. Bits 28:23 hold the packet flags in the order IPv4, TCP, broadcast, multicast, raw, protected (flag bit 0 lands in entry bit 23).
- R6: Entry bits 37:32 hold the L2 header byte length and bits 43:38 the L3 header dword length. Bits 47:44 hold the L4 header dword length, bits 53:48 the MCS and bits 55:54 the bonding mode. Bits 59:56 hold the data offset code (0 means no shift, 3 means a 2-byte shift), and bits 63:60 are zero.
- R7: Entry bits 79:64 hold the buffer id, bits 95:80 the byte length of this buffer, and bits 127:96 the timestamp.
- R8: A request accepted at a clock edge appears on the write port at that edge, addressed to the previous head. At the same edge the head advances by one, modulo the ring size.
- R9: When head+1 equals the software tail, in_ready is low. No write happens and the head holds, and the pending request is written once space frees up.
- R10: irq is a one-cycle pulse in the cycle after a write whose entry has bit 30 set. Writes without bit 30 set raise no pulse.
- R11: During reset and right after it, ring_we and irq are 0, the head is 0 and in_ready is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Buffer completion request |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_last | input | 1 | Buffer closes the MSDU |
| in_l2_status | input | 3 | Link-layer status code |
| in_l3_status | input | 2 | Network-layer checksum result |
| in_l4_status | input | 2 | Transport-layer checksum result |
| in_flow_id | input | 12 | Flow identifier |
| in_mac_id | input | 2 | MAC identifier |
| in_mac_id_vld | input | 1 | MAC identifier valid |
| in_pkt_flags | input | 6 | IPv4, TCP, broadcast, multicast, raw, protected (bit 0 first) |
| in_l2_hdr_len | input | 6 | L2 header length in bytes |
| in_l3_hdr_len | input | 6 | L3 header length in dwords |
| in_l4_hdr_len | input | 4 | L4 header length in dwords |
| in_mcs | input | 6 | Received MCS |
| in_bond_mode | input | 2 | Channel bonding mode |
| in_data_ofs | input | 4 | Data offset code |
| in_buf_id | input | 16 | Buffer identifier |
| in_byte_len | input | 16 | Valid bytes in this buffer |
| in_tstamp | input | 32 | Timestamp |
| sw_tail | input | ORDER | Software tail slot |
| ring_we | output | 1 | Ring write enable |
| ring_addr | output | ORDER | Ring write slot |
| ring_data | output | 128 | Ring entry |
| hw_head | output | ORDER | Next slot to write |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two situations are hard to reach from the ports: a full ring holding a request back, and the ready-bit inversion at the wrap. The bench gets to the full ring by moving the tail input to one past the head while a request is pending. It holds the request for several cycles before freeing space, then checks that exactly one write lands at the expected slot. Long random runs with the tail kept ahead of the head pass through the small ring several times, so the phase bit is checked across many wraps.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int ENTRY_W = 128;

  typedef struct packed {
    logic        last;
    logic [2:0]  l2_status;
    logic [1:0]  l3_status;
    logic [1:0]  l4_status;
    logic [11:0] flow_id;
    logic [1:0]  mac_id;
    logic        mac_id_vld;
    logic [5:0]  pkt_flags;
    logic [5:0]  l2_hdr_len;
    logic [5:0]  l3_hdr_len;
    logic [3:0]  l4_hdr_len;
    logic [5:0]  mcs;
    logic [1:0]  bond_mode;
    logic [3:0]  data_ofs;
    logic [15:0] buf_id;
    logic [15:0] byte_len;
    logic [31:0] tstamp;
  } rxs_req_t;
endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rxs_entry_fmt.sv
module rxs_entry_fmt
  import rxs_pkg::*;
(
  input  rxs_req_t             req,
  input  logic                 phase,
  output logic [ENTRY_W-1:0]   entry
);
  logic        err;
  logic [1:0]  mid;
  logic [31:0] w0, w1, w2, w3;

  always_comb begin
    err = (req.l2_status != 3'd0) || (req.l3_status == 2'd3) ||
          (req.l4_status == 2'd3);
    mid = req.mac_id_vld ? req.mac_id : 2'd0;
    w0  = {phase, req.last, err, req.pkt_flags, req.mac_id_vld, mid,
           req.flow_id, 1'b0, req.l4_status, req.l3_status, req.l2_status};
    w1  = {4'd0, req.data_ofs, req.bond_mode, req.mcs, req.l4_hdr_len,
           req.l3_hdr_len, req.l2_hdr_len};
    w2  = {req.byte_len, req.buf_id};
    w3  = req.tstamp;
    entry = {w3, w2, w1, w0};
  end
endmodule

// File: rtl/rxs_ring_ptr.sv
module rxs_ring_ptr #(
  parameter int ORDER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [ORDER-1:0] sw_tail,
  output logic [ORDER-1:0] head,
  output logic             phase,
  output logic             full
);
  localparam logic [ORDER-1:0] LAST_SLOT = {ORDER{1'b1}};

  logic [ORDER-1:0] head_q, head_d;
  logic             phase_q, phase_d;
  logic [ORDER-1:0] head_inc;

  always_comb begin
    head_inc = head_q + 1'b1;
    head_d   = head_q;
    phase_d  = phase_q;
    if (advance) begin
      head_d = head_inc;
      if (head_q == LAST_SLOT) phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      phase_q <= 1'b1;
    end else begin
      head_q  <= head_d;
      phase_q <= phase_d;
    end
  end

  assign head  = head_q;
  assign phase = phase_q;
  assign full  = (head_inc == sw_tail);
endmodule

// File: rtl/rxs_ring_writer.sv
module rxs_ring_writer
  import rxs_pkg::*;
#(
  parameter int ORDER       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_last,
  input  logic [2:0]         in_l2_status,
  input  logic [1:0]         in_l3_status,
  input  logic [1:0]         in_l4_status,
  input  logic [11:0]        in_flow_id,
  input  logic [1:0]         in_mac_id,
  input  logic               in_mac_id_vld,
  input  logic [5:0]         in_pkt_flags,
  input  logic [5:0]         in_l2_hdr_len,
  input  logic [5:0]         in_l3_hdr_len,
  input  logic [3:0]         in_l4_hdr_len,
  input  logic [5:0]         in_mcs,
  input  logic [1:0]         in_bond_mode,
  input  logic [3:0]         in_data_ofs,
  input  logic [15:0]        in_buf_id,
  input  logic [15:0]        in_byte_len,
  input  logic [31:0]        in_tstamp,
  input  logic [ORDER-1:0]   sw_tail,
  output logic               ring_we,
  output logic [ORDER-1:0]   ring_addr,
  output logic [ENTRY_W-1:0] ring_data,
  output logic [ORDER-1:0]   hw_head,
  output logic               irq
);
  localparam int EOP_BIT = 30;

  logic               srst_n;
  logic               accept;
  logic               full;
  logic               phase;
  logic [ORDER-1:0]   head;
  rxs_req_t           req;
  logic [ENTRY_W-1:0] entry;

  logic               we_q, we_d;
  logic [ORDER-1:0]   addr_q, addr_d;
  logic [ENTRY_W-1:0] data_q, data_d;
  logic               irq_q, irq_d;

  rxs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    req.last       = in_last;
    req.l2_status  = in_l2_status;
    req.l3_status  = in_l3_status;
    req.l4_status  = in_l4_status;
    req.flow_id    = in_flow_id;
    req.mac_id     = in_mac_id;
    req.mac_id_vld = in_mac_id_vld;
    req.pkt_flags  = in_pkt_flags;
    req.l2_hdr_len = in_l2_hdr_len;
    req.l3_hdr_len = in_l3_hdr_len;
    req.l4_hdr_len = in_l4_hdr_len;
    req.mcs        = in_mcs;
    req.bond_mode  = in_bond_mode;
    req.data_ofs   = in_data_ofs;
    req.buf_id     = in_buf_id;
    req.byte_len   = in_byte_len;
    req.tstamp     = in_tstamp;
  end

  rxs_entry_fmt u_fmt (
    .req   (req),
    .phase (phase),
    .entry (entry)
  );

  rxs_ring_ptr #(.ORDER(ORDER)) u_ptr (
    .clk     (clk),
    .rst_n   (srst_n),
    .advance (accept),
    .sw_tail (sw_tail),
    .head    (head),
    .phase   (phase),
    .full    (full)
  );

  assign in_ready = srst_n && !full;
  assign accept   = in_valid && in_ready;

  always_comb begin
    we_d   = accept;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      addr_d = head;
      data_d = entry;
    end
    irq_d = we_q && data_q[EOP_BIT];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  assign ring_we   = we_q;
  assign ring_addr = addr_q;
  assign ring_data = data_q;
  assign hw_head   = head;
  assign irq       = irq_q;
endmodule

// File: rtl/rxs_ring_writer_chk.sv
module rxs_ring_writer_chk #(
  parameter int ORDER = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ORDER-1:0] sw_tail,
  input logic             ring_we,
  input logic [ORDER-1:0] ring_addr,
  input logic [127:0]     ring_data,
  input logic [ORDER-1:0] hw_head,
  input logic             irq
);
  localparam logic [ORDER-1:0] LAST_SLOT = {ORDER{1'b1}};
  logic [ORDER-1:0] head_nxt;
  logic [ORDER-1:0] addr_nxt;
  assign head_nxt = hw_head + 1'b1;
  assign addr_nxt = ring_addr + 1'b1;

  // R2: summary error consistent with the written status fields
  p_err_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_we |-> ring_data[29] == ((ring_data[2:0] != 3'd0) ||
                                  (ring_data[4:3] == 2'd3) ||
                                  (ring_data[6:5] == 2'd3)));

  // R5: invalid MAC id is written as zero
  p_mid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_we && !ring_data[22]) |-> ring_data[21:20] == 2'd0);

  // R8: head sits one past the slot just written
  p_head_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_we |-> hw_head == addr_nxt);

  // R9: never accept into a full ring, and a stall writes nothing
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> head_nxt != sw_tail);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !ring_we);

  // R10: interrupt follows a committed end-of-MSDU entry
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ring_we && ring_data[30]));

  // R4: ready bit flips across consecutive writes that wrap
  p_phase_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_we && ring_addr == '0 && $past(ring_we) &&
     $past(ring_addr) == LAST_SLOT) |-> ring_data[31] != $past(ring_data[31]));
endmodule

bind rxs_ring_writer rxs_ring_writer_chk #(.ORDER(ORDER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .sw_tail   (sw_tail),
  .ring_we   (ring_we),
  .ring_addr (ring_addr),
  .ring_data (ring_data),
  .hw_head   (hw_head),
  .irq       (irq)
);

// File: tb/rxs_ring_writer_tb.sv
`timescale 1ns/1ps
module rxs_ring_writer_tb;
  localparam int ORDER = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last;
  logic [2:0] in_l2_status;
  logic [1:0] in_l3_status, in_l4_status;
  logic [11:0] in_flow_id;
  logic [1:0] in_mac_id;
  logic in_mac_id_vld;
  logic [5:0] in_pkt_flags, in_l2_hdr_len, in_l3_hdr_len, in_mcs;
  logic [3:0] in_l4_hdr_len, in_data_ofs;
  logic [1:0] in_bond_mode;
  logic [15:0] in_buf_id, in_byte_len;
  logic [31:0] in_tstamp;
  logic [ORDER-1:0] sw_tail;
  logic ring_we;
  logic [ORDER-1:0] ring_addr, hw_head;
  logic [127:0] ring_data;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [ORDER-1:0] exp_head;
  logic exp_phase;
  logic [127:0] exp_e;

  always #2 clk = ~clk;

  rxs_ring_writer #(.ORDER(ORDER)) u_dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model();
    logic err;
    logic [31:0] w0, w1;
    err = (in_l2_status != 0) || (in_l3_status == 3) || (in_l4_status == 3);
    w0 = {exp_phase, in_last, err, in_pkt_flags, in_mac_id_vld,
          (in_mac_id_vld ? in_mac_id : 2'd0), in_flow_id, 1'b0,
          in_l4_status, in_l3_status, in_l2_status};
    w1 = {4'd0, in_data_ofs, in_bond_mode, in_mcs, in_l4_hdr_len,
          in_l3_hdr_len, in_l2_hdr_len};
    return {in_tstamp, in_byte_len, in_buf_id, w1, w0};
  endfunction

  task automatic rand_fields();
    logic [31:0] r;
    r = $urandom;
    in_last       = r[0];
    in_l2_status  = (r[3:1] < 3) ? 3'($urandom) : 3'd0;
    in_l3_status  = 2'($urandom);
    in_l4_status  = 2'($urandom);
    in_flow_id    = 12'($urandom);
    in_mac_id     = 2'($urandom);
    in_mac_id_vld = r[4];
    in_pkt_flags  = 6'($urandom);
    in_l2_hdr_len = 6'($urandom);
    in_l3_hdr_len = 6'($urandom);
    in_l4_hdr_len = 4'($urandom);
    in_mcs        = 6'($urandom);
    in_bond_mode  = 2'($urandom);
    in_data_ofs   = r[5] ? 4'd3 : 4'd0;
    in_buf_id     = 16'($urandom);
    in_byte_len   = 16'($urandom);
    in_tstamp     = $urandom;
  endtask

  // called at negedge with in_valid high and in_ready high
  task automatic finish_accept();
    exp_e = model();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 we", 128'(ring_we), 128'(1'b1));
    chk("R8 addr", 128'(ring_addr), 128'(exp_head));
    chk("R1 status", 128'(ring_data[7:0]), 128'(exp_e[7:0]));
    chk("R2 err", 128'(ring_data[29]), 128'(exp_e[29]));
    chk("R3 eop", 128'(ring_data[30]), 128'(exp_e[30]));
    chk("R4 ready", 128'(ring_data[31]), 128'(exp_e[31]));
    chk("R5 dword0", 128'(ring_data[28:8]), 128'(exp_e[28:8]));
    chk("R6 dword1", 128'(ring_data[63:32]), 128'(exp_e[63:32]));
    chk("R7 dword2/3", 128'(ring_data[127:64]), 128'(exp_e[127:64]));
    if (exp_head == {ORDER{1'b1}}) exp_phase = ~exp_phase;
    exp_head = exp_head + 1'b1;
    chk("R8 head", 128'(hw_head), 128'(exp_head));
    @(posedge clk); #1;
    chk("R10 irq", 128'(irq), 128'(in_last));
    chk("R8 single write", 128'(ring_we), 128'(1'b0));
  endtask

  task automatic send_one();
    @(negedge clk);
    sw_tail = exp_head + 3'd4;
    in_valid = 1'b1;
    #0.5;
    chk("R9 ready when space", 128'(in_ready), 128'(1'b1));
    finish_accept();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; sw_tail = '0;
    rand_fields();
    exp_head = '0; exp_phase = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", 128'(in_ready), 128'(1'b0));
    chk("R11 we in reset", 128'(ring_we), 128'(1'b0));
    chk("R11 irq in reset", 128'(irq), 128'(1'b0));
    chk("R11 head in reset", 128'(hw_head), 128'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 we after reset", 128'(ring_we), 128'(1'b0));
    chk("R11 head after reset", 128'(hw_head), 128'(0));

    // directed: error corners
    rand_fields(); in_l2_status = 0; in_l3_status = 3; in_l4_status = 1; in_last = 1; send_one();
    rand_fields(); in_l2_status = 0; in_l3_status = 2; in_l4_status = 2; in_last = 0; send_one();
    rand_fields(); in_l2_status = 0; in_l3_status = 1; in_l4_status = 3; send_one();
    rand_fields(); in_l2_status = 7; in_l3_status = 0; in_l4_status = 0; send_one();
    rand_fields(); in_mac_id = 2'd3; in_mac_id_vld = 0; send_one();
    rand_fields(); in_mac_id = 2'd2; in_mac_id_vld = 1; send_one();

    // random traffic through many wraps
    for (int i = 0; i < 50; i++) begin
      rand_fields();
      send_one();
    end

    // full ring: request held back, then accepted
    @(negedge clk);
    rand_fields(); in_last = 1'b1;
    sw_tail = exp_head + 1'b1;
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #0.5;
      chk("R9 ready low when full", 128'(in_ready), 128'(1'b0));
      chk("R9 no write when full", 128'(ring_we), 128'(1'b0));
      chk("R9 head held", 128'(hw_head), 128'(exp_head));
      @(negedge clk);
    end
    sw_tail = exp_head + 3'd3;
    #0.5;
    chk("R9 ready after space", 128'(in_ready), 128'(1'b1));
    finish_accept();

    // a few more to cross a wrap after the stall
    for (int i = 0; i < 10; i++) begin
      rand_fields();
      send_one();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule